// File: doc/BRIEF.md
# Thermal Alarm Assertion Duration Timer

This block watches an active-low thermal alarm input and measures how long it has been held active. Time is counted in fixed steps (22.76 ms each in the target system), and the step length comes from a prescaler on the system clock. The prescaler's cycle count is a parameter, so the bench can use a very short step. The count builds up over separate alarm episodes until the host reads it. It stops at its maximum value and does not roll over.

The host uses a small register port with an address, a write strobe and a read strobe. The port has three registers:
- a duration register, cleared on read;
- a read/write limit register;
- an alarm flag, set when the measured duration passes the limit and cleared on read.

The alarm flag is also driven on a dedicated output pin. A duration register that reads below two steps shows only an "alarm seen" flag in bit 0. From two steps up it shows the full step count.

Top module: `therm_dur_timer`

## Requirements
- R1: After reset, the duration register (address 0), the limit register (address 1) and the alarm register (address 2) all read 0x00, and `alarm_o` is 0.
- R2: `therm_n_i` is active low and passes through a two-flop synchronizer. When the input goes low, bit 0 of the duration register reads 1 from the third rising clock edge onward.
- R3: While the synchronized input is active, the step count rises by one for every `TICK_CYCLES` clock edges. The partial progress of the prescaler is kept while the input is inactive, so the counted time builds up across separate episodes.
- R4: While the step count is below 2, bits 7:1 of the duration register read 0 and bit 0 is the "seen" flag. At 2 steps or more, the register reads the step count itself.
- R5: The step count saturates at 255 and never wraps.
- R6: A read of address 0 returns the value from before the clear. At that clock edge the step count and the seen flag are cleared. If an assertion edge falls in the same cycle, the seen flag stays 1. If a step falls in the same cycle, the count restarts at 1.
- R7: A write to address 1 loads the limit register at that clock edge, and address 1 reads it back.
- R8: The alarm flag is bit 0 of address 2 (bits 7:1 read 0) and is also driven on `alarm_o`. It is set in any cycle where the synchronized input is active and either the limit is 0 or the step count is greater than the limit. Once set, it stays set until address 2 is read. A read of address 2 clears it, except when the set condition holds in the same cycle.
- R9: Writes to addresses 0, 2 and 3 have no effect, and address 3 reads 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| therm_n_i | input | 1 | Raw thermal alarm input, active low |
| reg_addr_i | input | 2 | Register address |
| reg_wr_i | input | 1 | Write strobe |
| reg_rd_i | input | 1 | Read strobe (clears the addressed clear-on-read register) |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data for the current address, combinational |
| alarm_o | output | 1 | Sticky over-limit alarm flag |

## Verification
The input is driven with several kinds of episode, and each one separates a different behaviour:
- Episodes too short to make two steps show the seen-flag format.
- Longer episodes show the switch to the full count.
- Split episodes whose total crosses a step boundary show whether partial prescaler progress is kept.
- One very long episode shows saturation.

The limit is tried at zero and at a small non-zero value, so an immediate alarm can be told apart from a threshold alarm. Reads are placed on the same cycle as an assertion edge and while the alarm condition still holds, so that the set-wins priority is exercised.

// File: rtl/therm_pkg.sv
`timescale 1ns/1ps
package therm_pkg;
  localparam int TMR_W    = 8;
  localparam int ADDR_W   = 2;
  localparam int SHOW_MIN = 2;

  typedef logic [TMR_W-1:0] tmr_t;

  localparam logic [ADDR_W-1:0] A_DUR = 2'd0;
  localparam logic [ADDR_W-1:0] A_LIM = 2'd1;
  localparam logic [ADDR_W-1:0] A_ALM = 2'd2;

  // Host view of the duration register: flag only below SHOW_MIN steps.
  function automatic tmr_t f_reading(tmr_t steps, logic seen);
    if (steps >= tmr_t'(SHOW_MIN)) return steps;
    return {{(TMR_W-1){1'b0}}, seen};
  endfunction

  // Saturating increment.
  function automatic tmr_t f_sat_inc(tmr_t v);
    if (v == '1) return v;
    return v + tmr_t'(1);
  endfunction

  // Over-limit test; a zero limit trips at once.
  function automatic logic f_over(tmr_t steps, tmr_t lim);
    return (lim == '0) || (steps > lim);
  endfunction
endpackage

// File: rtl/therm_sync.sv
`timescale 1ns/1ps
module therm_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din_n,
  output logic act,
  output logic act_rise
);
  logic [STAGES-1:0] sh;
  logic              act_q;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) sh[g] <= 1'b1;
          else        sh[g] <= din_n;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) sh[g] <= 1'b1;
          else        sh[g] <= sh[g-1];
      end
    end
  endgenerate

  assign act = ~sh[STAGES-1];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) act_q <= 1'b0;
    else        act_q <= act;

  assign act_rise = act & ~act_q;
endmodule

// File: rtl/therm_prescaler.sv
`timescale 1ns/1ps
module therm_prescaler #(
  parameter int TICK_CYCLES = 1138000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic tick
);
  localparam int PRE_W = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1;
  localparam logic [PRE_W-1:0] LAST = PRE_W'(TICK_CYCLES - 1);

  logic [PRE_W-1:0] pre;

  assign tick = en && (pre == LAST);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)    pre <= '0;
    else if (tick) pre <= '0;
    else if (en)   pre <= pre + PRE_W'(1);
endmodule

// File: rtl/therm_dur_core.sv
`timescale 1ns/1ps
module therm_dur_core
  import therm_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic act,
  input  logic act_rise,
  input  logic tick,
  input  logic clr_stat,
  input  logic clr_alarm,
  input  tmr_t limit,
  output tmr_t steps,
  output logic seen,
  output logic alarm,
  output logic alarm_set,
  output tmr_t reading
);
  assign alarm_set = act && f_over(steps, limit);
  assign reading   = f_reading(steps, seen);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)        steps <= '0;
    else if (clr_stat) steps <= tick ? tmr_t'(1) : '0;
    else if (tick)     steps <= f_sat_inc(steps);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)        seen <= 1'b0;
    else if (act_rise) seen <= 1'b1;
    else if (clr_stat) seen <= 1'b0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)         alarm <= 1'b0;
    else if (alarm_set) alarm <= 1'b1;
    else if (clr_alarm) alarm <= 1'b0;
endmodule

// File: rtl/therm_dur_regs.sv
`timescale 1ns/1ps
module therm_dur_regs
  import therm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic              rd,
  input  tmr_t              wdata,
  input  tmr_t              reading,
  input  logic              alarm,
  output tmr_t              limit,
  output tmr_t              rdata,
  output logic              clr_stat,
  output logic              clr_alarm
);
  assign clr_stat  = rd && (addr == A_DUR);
  assign clr_alarm = rd && (addr == A_ALM);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                      limit <= '0;
    else if (wr && (addr == A_LIM))  limit <= wdata;

  always_comb begin
    unique case (addr)
      A_DUR:   rdata = reading;
      A_LIM:   rdata = limit;
      A_ALM:   rdata = {{(TMR_W-1){1'b0}}, alarm};
      default: rdata = '0;
    endcase
  end
endmodule

// File: rtl/therm_dur_timer.sv
`timescale 1ns/1ps
module therm_dur_timer
  import therm_pkg::*;
#(
  parameter int TICK_CYCLES = 1138000,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              therm_n_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic              reg_wr_i,
  input  logic              reg_rd_i,
  input  logic [TMR_W-1:0]  reg_wdata_i,
  output logic [TMR_W-1:0]  reg_rdata_o,
  output logic              alarm_o
);
  logic act, act_rise, tick, clr_stat, clr_alarm, seen, alarm_set;
  tmr_t steps, limit, reading;

  therm_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din_n(therm_n_i), .act(act), .act_rise(act_rise)
  );

  therm_prescaler #(.TICK_CYCLES(TICK_CYCLES)) u_pre (
    .clk(clk), .rst_n(rst_n), .en(act), .tick(tick)
  );

  therm_dur_core u_core (
    .clk(clk), .rst_n(rst_n), .act(act), .act_rise(act_rise), .tick(tick),
    .clr_stat(clr_stat), .clr_alarm(clr_alarm), .limit(limit),
    .steps(steps), .seen(seen), .alarm(alarm_o), .alarm_set(alarm_set),
    .reading(reading)
  );

  therm_dur_regs u_regs (
    .clk(clk), .rst_n(rst_n), .addr(reg_addr_i), .wr(reg_wr_i), .rd(reg_rd_i),
    .wdata(reg_wdata_i), .reading(reading), .alarm(alarm_o), .limit(limit),
    .rdata(reg_rdata_o), .clr_stat(clr_stat), .clr_alarm(clr_alarm)
  );
endmodule

// File: rtl/therm_dur_timer_chk.sv
`timescale 1ns/1ps
module therm_dur_timer_chk
  import therm_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              act,
  input logic              act_rise,
  input logic              tick,
  input logic              clr_stat,
  input logic              clr_alarm,
  input logic              seen,
  input tmr_t              steps,
  input tmr_t              limit,
  input logic              alarm_o,
  input logic              reg_wr_i,
  input logic [ADDR_W-1:0] reg_addr_i,
  input tmr_t              reg_wdata_i
);
  // R2: an assertion edge always leaves the seen flag set
  a_r2_seen_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    act_rise |=> seen);

  // R3: no step is counted while the input is inactive
  a_r3_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!act && !clr_stat) |=> $stable(steps));

  // R5: saturated count stays saturated
  a_r5_saturate: assert property (@(posedge clk) disable iff (!rst_n)
    (steps == '1 && !clr_stat) |=> steps == '1);

  // R6: a read of the duration register empties the count
  a_r6_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_stat && !tick) |=> steps == '0);

  // R7: limit write lands at the strobe edge
  a_r7_limit_wr: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_i && reg_addr_i == A_LIM) |=> limit == $past(reg_wdata_i));

  // R8: alarm is sticky until its register is read
  a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (alarm_o && !clr_alarm) |=> alarm_o);

  // R8: zero limit trips the alarm as soon as the input is active
  a_r8_zero_limit: assert property (@(posedge clk) disable iff (!rst_n)
    (act && limit == '0) |=> alarm_o);
endmodule

bind therm_dur_timer therm_dur_timer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .act(act), .act_rise(act_rise), .tick(tick),
  .clr_stat(clr_stat), .clr_alarm(clr_alarm), .seen(seen), .steps(steps),
  .limit(limit), .alarm_o(alarm_o), .reg_wr_i(reg_wr_i),
  .reg_addr_i(reg_addr_i), .reg_wdata_i(reg_wdata_i)
);

// File: tb/therm_dur_timer_tb.sv
`timescale 1ns/1ps
module therm_dur_timer_tb;
  localparam int TICK = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       therm_n = 1'b1;
  logic [1:0] addr = 2'd0;
  logic       wr = 1'b0;
  logic       rd = 1'b0;
  logic [7:0] wdata = 8'd0;
  logic [7:0] rdata;
  logic       alarm;

  int checks = 0;
  int fails  = 0;
  bit run_cmp = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  therm_dur_timer #(.TICK_CYCLES(TICK)) u_dut (
    .clk(clk), .rst_n(rst_n), .therm_n_i(therm_n), .reg_addr_i(addr),
    .reg_wr_i(wr), .reg_rd_i(rd), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .alarm_o(alarm)
  );

  // ---------------- behavioural reference model ----------------
  bit sync_q[$];
  bit m_act_d;
  int m_pre, m_steps, m_lim;
  bit m_seen, m_alarm;

  function automatic int m_view(int a);
    case (a)
      0: return (m_steps >= 2) ? m_steps : int'(m_seen);
      1: return m_lim;
      2: return int'(m_alarm);
      default: return 0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q = '{1'b1, 1'b1};
      m_act_d = 0; m_pre = 0; m_steps = 0; m_lim = 0;
      m_seen = 0; m_alarm = 0;
    end else begin
      bit a_now, rise, stp, hit, cs, ca;
      a_now = !sync_q[1];
      rise  = a_now && !m_act_d;
      stp   = a_now && (m_pre == TICK - 1);
      hit   = a_now && ((m_lim == 0) || (m_steps > m_lim));
      cs    = rd && addr == 2'd0;
      ca    = rd && addr == 2'd2;
      if (stp) m_pre = 0; else if (a_now) m_pre++;
      if (cs) m_steps = stp ? 1 : 0;
      else if (stp && m_steps < 255) m_steps++;
      if (rise) m_seen = 1; else if (cs) m_seen = 0;
      if (hit) m_alarm = 1; else if (ca) m_alarm = 0;
      if (wr && addr == 2'd1) m_lim = int'(wdata);
      m_act_d = a_now;
      void'(sync_q.pop_back());
      sync_q.push_front(therm_n);
    end
  end

  task automatic chk(string tag, int got, int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s got=%0d exp=%0d at %0t", tag, got, exp, $time);
    end
  endtask

  // per-cycle comparison, mid-cycle
  always @(negedge clk) begin
    if (rst_n && run_cmp) begin
      chk("R4 model rdata", int'(rdata), m_view(int'(addr)));
      chk("R8 model alarm", int'(alarm), int'(m_alarm));
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic cyc(int n);
    repeat (n) @(posedge clk);
    #5;
  endtask

  task automatic peek(int a, output int v);
    addr = 2'(a);
    @(negedge clk);
    v = int'(rdata);
    cyc(1);
  endtask

  task automatic rd_reg(int a, output int v);
    addr = 2'(a); rd = 1'b1;
    @(negedge clk);
    v = int'(rdata);
    cyc(1);
    rd = 1'b0;
  endtask

  task automatic wr_reg(int a, int d);
    addr = 2'(a); wdata = 8'(d); wr = 1'b1;
    cyc(1);
    wr = 1'b0;
  endtask

  task automatic hold(int n);
    therm_n = 1'b0;
    cyc(n);
    therm_n = 1'b1;
    cyc(4);
  endtask

  initial begin
    #(200000 * 20);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int v;
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
    run_cmp = 1'b1;

    // R1 reset state
    peek(0, v); chk("R1 dur reset", v, 0);
    peek(1, v); chk("R1 limit reset", v, 0);
    peek(2, v); chk("R1 alarm reg reset", v, 0);
    chk("R1 alarm_o reset", int'(alarm), 0);

    // R3 42 active edges at 4 per step -> 10 steps
    hold(42);
    peek(0, v); chk("R3 ten steps", v, 10);
    chk("R8 zero limit alarm", int'(alarm), 1);

    // R6 read returns pre-clear value then empties
    rd_reg(0, v); chk("R6 read old value", v, 10);
    peek(0, v); chk("R6 cleared", v, 0);

    // R4 two steps shows count; R3 prescaler progress carried over
    hold(7);
    peek(0, v); chk("R4 two steps", v, 2);
    hold(3);
    peek(0, v); chk("R3 accumulate across episodes", v, 3);

    // R2 short episode: only bit 0 set
    rd_reg(0, v);
    hold(2);
    peek(0, v); chk("R2 seen flag only", v, 1);

    // R6 read in the same cycle as assertion edge
    rd_reg(0, v);
    peek(0, v); chk("R6 emptied before collision", v, 0);
    therm_n = 1'b0;
    cyc(2);
    addr = 2'd0; rd = 1'b1;
    cyc(1);
    rd = 1'b0;
    @(negedge clk);
    chk("R6 edge beats clear", int'(rdata[0]), 1);
    cyc(1);
    therm_n = 1'b1;
    cyc(4);

    // R5 saturation
    hold(1100);
    peek(0, v); chk("R5 saturate", v, 255);

    // R7 limit read/write; R9 ignored writes
    wr_reg(1, 3);
    peek(1, v); chk("R7 limit readback", v, 3);
    wr_reg(0, 8'hAA);
    peek(0, v); chk("R9 write to dur ignored", v, 255);
    wr_reg(2, 0);
    peek(2, v); chk("R9 write to alarm ignored", v, 1);
    wr_reg(3, 8'h55);
    peek(3, v); chk("R9 addr3 reads zero", v, 0);

    // R8 threshold alarm with limit 3
    rd_reg(0, v);
    rd_reg(2, v); chk("R8 alarm reg read", v, 1);
    peek(2, v); chk("R8 alarm cleared", v, 0);
    hold(12);
    chk("R8 at limit no alarm", int'(alarm), 0);
    hold(20);
    chk("R8 above limit alarm", int'(alarm), 1);

    // R8 read while set condition holds keeps alarm
    wr_reg(1, 0);
    therm_n = 1'b0;
    cyc(4);
    rd_reg(2, v);
    chk("R8 set beats clear", int'(alarm), 1);
    therm_n = 1'b1;
    cyc(4);
    rd_reg(2, v);
    chk("R8 clear when idle", int'(alarm), 0);

    cyc(2);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule